// File: doc/BRIEF.md
# Companded Interpolating Polar Predistortion Table

This block predistorts a stream of amplitude samples for a power amplifier that works in polar form. Each input amplitude first goes through a compander: a small, uniformly spaced, linearly interpolated table. The compander turns the amplitude into a fixed-point coordinate. Because the compander curve can be any piecewise-linear shape, the breakpoints of the two main tables can sit unevenly along the amplitude axis. They can be packed densely where the signal spends most of its time, and the tables can still stay short.

The coordinate's integer part selects a segment of two main tables and its fractional part interpolates between neighbouring entries. The first main table holds the inverse of the amplifier's amplitude compression. The second holds a signed phase correction, which is the negated phase distortion of the amplifier. The corrected amplitude and the phase offset leave together with a valid flag, a fixed number of cycles after the sample entered. All three tables are loaded through a write-only host port. Coefficient training, polar conversion and the phase rotator sit outside the block.

Top module: `pdl_predistorter`

## Requirements
- R1: `out_amp` is taken from the amplitude table and treated as unsigned. `out_phase` is taken from the phase table and is a signed two's-complement value.
- R2: The main tables are interpolated as follows. Let i = coordinate[15:10] and f = coordinate[9:0]. An output is T[i] + floor((T[i+1] - T[i]) * f / 1024), computed in full precision and kept to its low 16 bits.
- R3: The compander is interpolated as follows. Let s = in_amp[15:8] and r = in_amp[7:0]. The coordinate is C[s] + floor((C[s+1] - C[s]) * r / 256), and C entries are unsigned 16-bit values.
- R4: In the last compander segment (s = 255), C[255] is used in place of C[s+1], so the coordinate equals C[255] for every r.
- R5: At the last main-table entry (i = 63), T[63] is used in place of T[i+1], so the output equals T[63] for every f.
- R6: A sample presented with `in_valid` high in cycle c appears on the outputs in cycle c+6, with `out_valid` high. `out_valid` is high in exactly those cycles. Samples can arrive on consecutive cycles without any gap.
- R7: While `rst_n` is low, `out_valid`, `out_amp` and `out_phase` are all zero.
- R8: A host write happens when `cfg_we` is high. `cfg_sel` picks the table: 0 is the compander (entry `cfg_addr`), 1 is the amplitude table and 2 is the phase table. A main-table write with `cfg_addr` of 64 or more has no effect, and neither does any write with `cfg_sel` = 3.
- R9: A write presented in the same cycle as a sample, or earlier, is used by that sample. A compander write leaves unchanged every sample presented before the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_amp | input | 16 | Input amplitude, unsigned |
| cfg_we | input | 1 | Host write strobe |
| cfg_sel | input | 2 | Table select: 0 compander, 1 amplitude, 2 phase, 3 none |
| cfg_addr | input | 8 | Table entry index |
| cfg_data | input | 16 | Entry value to write |
| out_valid | output | 1 | Output sample qualifier |
| out_amp | output | 16 | Predistorted amplitude, unsigned |
| out_phase | output | 16 | Phase correction, signed |

## Verification
The bounds assertions take for granted that every table entry already holds a written value when a valid sample reads it. The bench therefore loads all 256 compander entries and all 64 entries of each main table before it sends any sample. The write-timing rule assumes that writes to a main table never overlap with samples still inside the pipeline. The bench flushes the pipeline before each main-table load and only rewrites the compander while samples are streaming, because the write's effect on that table is exact at the cycle boundary.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    // Host table select codes
    typedef enum logic [1:0] {
        SEL_COMP  = 2'd0,
        SEL_AMP   = 2'd1,
        SEL_PHASE = 2'd2,
        SEL_NONE  = 2'd3
    } tbl_sel_e;

endpackage

// File: rtl/pdl_table.sv
// Register-file table with one write port and a pair of neighbouring reads.
// The upper read saturates at the final entry.
module pdl_table #(
    parameter int ABITS = 6,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [ABITS-1:0] wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [ABITS-1:0] rd_addr,
    output logic [DW-1:0]    rd_lo,
    output logic [DW-1:0]    rd_hi
);
    localparam int DEPTH = 1 << ABITS;

    logic [DW-1:0]    mem [DEPTH];
    logic [ABITS-1:0] nxt_addr;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        nxt_addr = (rd_addr == '1) ? rd_addr : rd_addr + ABITS'(1);
        rd_lo    = mem[rd_addr];
        rd_hi    = mem[nxt_addr];
    end

endmodule

// File: rtl/pdl_lerp.sv
// Linear interpolation lo + floor((hi - lo) * frac / 2^FW), signed or unsigned entries.
module pdl_lerp #(
    parameter int DW     = 16,
    parameter int FW     = 10,
    parameter bit SIGNED = 1'b0
) (
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic [FW-1:0] frac,
    output logic [DW-1:0] y
);
    localparam int EW = DW + 2;
    localparam int PW = DW + FW + 3;

    logic signed [EW-1:0] lo_e;
    logic signed [EW-1:0] hi_e;
    logic signed [EW-1:0] span;
    logic signed [PW-1:0] span_w;
    logic signed [PW-1:0] frac_w;
    logic signed [PW-1:0] lo_w;
    logic signed [PW-1:0] prod;

    generate
        if (SIGNED) begin : g_signed
            assign lo_e = {{2{lo[DW-1]}}, lo};
            assign hi_e = {{2{hi[DW-1]}}, hi};
        end else begin : g_unsigned
            assign lo_e = {2'b00, lo};
            assign hi_e = {2'b00, hi};
        end
    endgenerate

    assign span   = hi_e - lo_e;
    assign span_w = {{(PW-EW){span[EW-1]}}, span};
    assign frac_w = {{(PW-FW){1'b0}}, frac};
    assign lo_w   = {{(PW-EW){lo_e[EW-1]}}, lo_e};
    assign prod   = span_w * frac_w;
    assign y      = DW'(lo_w + (prod >>> FW));

endmodule

// File: rtl/pdl_predistorter.sv
module pdl_predistorter
    import pdl_pkg::*;
#(
    parameter int AMP_W    = 16,
    parameter int SEG_BITS = 8,
    parameter int COORD_W  = 16,
    parameter int IDX_BITS = 6,
    parameter int DATA_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [AMP_W-1:0]    in_amp,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [SEG_BITS-1:0] cfg_addr,
    input  logic [DATA_W-1:0]   cfg_data,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_amp,
    output logic [DATA_W-1:0]   out_phase
);
    localparam int IN_FRAC = AMP_W - SEG_BITS;
    localparam int CO_FRAC = COORD_W - IDX_BITS;

    // ---------------- host write decode ----------------
    logic main_addr_ok;
    logic we_comp, we_amp, we_phase;

    assign main_addr_ok = (cfg_addr[SEG_BITS-1:IDX_BITS] == '0);
    assign we_comp  = cfg_we && (cfg_sel == SEL_COMP);
    assign we_amp   = cfg_we && (cfg_sel == SEL_AMP)   && main_addr_ok;
    assign we_phase = cfg_we && (cfg_sel == SEL_PHASE) && main_addr_ok;

    // ---------------- stage 1: capture input ----------------
    logic             v1;
    logic [AMP_W-1:0] amp1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1   <= 1'b0;
            amp1 <= '0;
        end else begin
            v1   <= in_valid;
            amp1 <= in_amp;
        end
    end

    // ---------------- stage 2: compander read ----------------
    logic [COORD_W-1:0] c_lo, c_hi;

    pdl_table #(.ABITS(SEG_BITS), .DW(COORD_W)) u_comp (
        .clk     (clk),
        .wr_en   (we_comp),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data[COORD_W-1:0]),
        .rd_addr (amp1[AMP_W-1 -: SEG_BITS]),
        .rd_lo   (c_lo),
        .rd_hi   (c_hi)
    );

    logic               v2;
    logic [COORD_W-1:0] c_lo2, c_hi2;
    logic [IN_FRAC-1:0] fr2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v2    <= 1'b0;
            c_lo2 <= '0;
            c_hi2 <= '0;
            fr2   <= '0;
        end else begin
            v2    <= v1;
            c_lo2 <= c_lo;
            c_hi2 <= c_hi;
            fr2   <= amp1[IN_FRAC-1:0];
        end
    end

    // ---------------- stage 3: compander interpolation ----------------
    logic [COORD_W-1:0] coord_n;

    pdl_lerp #(.DW(COORD_W), .FW(IN_FRAC), .SIGNED(1'b0)) u_comp_lerp (
        .lo   (c_lo2),
        .hi   (c_hi2),
        .frac (fr2),
        .y    (coord_n)
    );

    logic               v3;
    logic [COORD_W-1:0] coord3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v3     <= 1'b0;
            coord3 <= '0;
        end else begin
            v3     <= v2;
            coord3 <= coord_n;
        end
    end

    // ---------------- stage 4: main table reads ----------------
    logic [IDX_BITS-1:0] idx3;
    logic [DATA_W-1:0]   a_lo, a_hi, p_lo, p_hi;

    assign idx3 = coord3[COORD_W-1 -: IDX_BITS];

    pdl_table #(.ABITS(IDX_BITS), .DW(DATA_W)) u_amp_tbl (
        .clk     (clk),
        .wr_en   (we_amp),
        .wr_addr (cfg_addr[IDX_BITS-1:0]),
        .wr_data (cfg_data),
        .rd_addr (idx3),
        .rd_lo   (a_lo),
        .rd_hi   (a_hi)
    );

    pdl_table #(.ABITS(IDX_BITS), .DW(DATA_W)) u_phase_tbl (
        .clk     (clk),
        .wr_en   (we_phase),
        .wr_addr (cfg_addr[IDX_BITS-1:0]),
        .wr_data (cfg_data),
        .rd_addr (idx3),
        .rd_lo   (p_lo),
        .rd_hi   (p_hi)
    );

    logic               v4;
    logic [DATA_W-1:0]  a_lo4, a_hi4, p_lo4, p_hi4;
    logic [CO_FRAC-1:0] f4;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v4    <= 1'b0;
            a_lo4 <= '0;
            a_hi4 <= '0;
            p_lo4 <= '0;
            p_hi4 <= '0;
            f4    <= '0;
        end else begin
            v4    <= v3;
            a_lo4 <= a_lo;
            a_hi4 <= a_hi;
            p_lo4 <= p_lo;
            p_hi4 <= p_hi;
            f4    <= coord3[CO_FRAC-1:0];
        end
    end

    // ---------------- stage 5: main interpolation ----------------
    logic [DATA_W-1:0] amp_n, ph_n;

    pdl_lerp #(.DW(DATA_W), .FW(CO_FRAC), .SIGNED(1'b0)) u_amp_lerp (
        .lo   (a_lo4),
        .hi   (a_hi4),
        .frac (f4),
        .y    (amp_n)
    );

    pdl_lerp #(.DW(DATA_W), .FW(CO_FRAC), .SIGNED(1'b1)) u_phase_lerp (
        .lo   (p_lo4),
        .hi   (p_hi4),
        .frac (f4),
        .y    (ph_n)
    );

    logic              v5;
    logic [DATA_W-1:0] amp5, ph5;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v5   <= 1'b0;
            amp5 <= '0;
            ph5  <= '0;
        end else begin
            v5   <= v4;
            amp5 <= amp_n;
            ph5  <= ph_n;
        end
    end

    // ---------------- stage 6: output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_amp   <= '0;
            out_phase <= '0;
        end else begin
            out_valid <= v5;
            out_amp   <= amp5;
            out_phase <= ph5;
        end
    end

    // ---------------- assertions ----------------
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd6) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    // R6: out_valid follows in_valid six cycles later
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd6) |-> (out_valid == $past(in_valid, 6)));

    // R3: the coordinate stays inside the span of its two compander entries
    a_r3_coord_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |=> ((coord3 >= (($past(c_lo2) < $past(c_hi2)) ? $past(c_lo2) : $past(c_hi2))) &&
                (coord3 <= (($past(c_lo2) < $past(c_hi2)) ? $past(c_hi2) : $past(c_lo2)))));

    // R4: the last compander segment reads the same entry twice
    a_r4_last_seg_flat: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 && (amp1[AMP_W-1 -: SEG_BITS] == '1)) |=> (c_lo2 == c_hi2));

    // R5: the last main entry reads the same entry twice in both tables
    a_r5_last_entry_flat: assert property (@(posedge clk) disable iff (!rst_n)
        (v3 && (idx3 == '1)) |=> ((a_lo4 == a_hi4) && (p_lo4 == p_hi4)));

    // R2: interpolated amplitude stays inside its segment
    a_r2_amp_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        v4 |=> ((amp5 >= (($past(a_lo4) < $past(a_hi4)) ? $past(a_lo4) : $past(a_hi4))) &&
                (amp5 <= (($past(a_lo4) < $past(a_hi4)) ? $past(a_hi4) : $past(a_lo4)))));

    // R1: signed phase correction stays inside its segment
    a_r1_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        v4 |=> (($signed(ph5) >= (($signed($past(p_lo4)) < $signed($past(p_hi4))) ? $signed($past(p_lo4)) : $signed($past(p_hi4)))) &&
                ($signed(ph5) <= (($signed($past(p_lo4)) < $signed($past(p_hi4))) ? $signed($past(p_hi4)) : $signed($past(p_lo4))))));

endmodule

// File: tb/tb_pdl_predistorter.sv
`timescale 1ns/1ps
module tb_pdl_predistorter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_amp = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic        out_valid;
    logic [15:0] out_amp;
    logic [15:0] out_phase;

    always #10 clk = ~clk;

    pdl_predistorter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_amp    (in_amp),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .out_valid (out_valid),
        .out_amp   (out_amp),
        .out_phase (out_phase)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // behavioural model
    int m_comp [256];
    int m_amp  [64];
    int m_ph   [64];

    int    qv [$];
    int    qa [$];
    int    qp [$];
    string qt [$];

    function automatic int lerp(int lo, int hi, int f, int fb);
        return lo + (((hi - lo) * f) >>> fb);
    endfunction

    function automatic void model_out(int a, output int ea, output int ep);
        int seg, fr, nx, coord, idx, f, ni;
        seg   = (a >> 8) & 255;
        fr    = a & 255;
        nx    = (seg == 255) ? 255 : seg + 1;
        coord = lerp(m_comp[seg], m_comp[nx], fr, 8);
        idx   = (coord >> 10) & 63;
        f     = coord & 1023;
        ni    = (idx == 63) ? 63 : idx + 1;
        ea    = lerp(m_amp[idx], m_amp[ni], f, 10) & 16'hFFFF;
        ep    = lerp(m_ph[idx], m_ph[ni], f, 10);
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input int a, input bit we, input int sel,
                        input int addr, input int data, input string tag);
        int ea, ep, ev;
        string et;
        @(negedge clk);
        if (qv.size() == 6) begin
            ev = qv.pop_front();
            ea = qa.pop_front();
            ep = qp.pop_front();
            et = qt.pop_front();
            check(out_valid == ev[0], "R6", "out_valid", int'(out_valid), ev);
            if (ev != 0) begin
                check(int'(out_amp) == ea, et, "out_amp", int'(out_amp), ea);
                check(int'($signed(out_phase)) == ep, et, "out_phase", int'($signed(out_phase)), ep);
            end
        end
        in_valid = v;
        in_amp   = a[15:0];
        cfg_we   = we;
        cfg_sel  = sel[1:0];
        cfg_addr = addr[7:0];
        cfg_data = data[15:0];
        if (we) begin
            int d;
            d = data & 16'hFFFF;
            if (sel == 0) m_comp[addr & 255] = d;
            else if (sel == 1 && addr < 64) m_amp[addr] = d;
            else if (sel == 2 && addr < 64) m_ph[addr] = (d >= 32768) ? d - 65536 : d;
        end
        model_out(a, ea, ep);
        qv.push_back(v ? 1 : 0);
        qa.push_back(ea);
        qp.push_back(ep);
        qt.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0, 0, 0, "R6");
    endtask

    task automatic sample(input int a, input string tag);
        step(1'b1, a, 1'b0, 0, 0, 0, tag);
    endtask

    task automatic write(input int sel, input int addr, input int data);
        step(1'b0, 0, 1'b1, sel, addr, data, "R8");
    endtask

    task automatic load_main();
        for (int i = 0; i < 64; i++) begin
            write(1, i, i * 1000 + ((i * i) % 7) * 30);
            write(2, i, -(i * i * 7) + i * 150 - 500);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7", "out_valid", int'(out_valid), 0);
        check(out_amp == 16'd0, "R7", "out_amp", int'(out_amp), 0);
        check(out_phase == 16'd0, "R7", "out_phase", int'(out_phase), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // linear compander, nonlinear main tables
        for (int k = 0; k < 256; k++) write(0, k, k * 256);
        load_main();
        sample(0, "R1 R2 R3");
        sample(1, "R2 R3");
        sample(255, "R3");
        sample(256, "R3");
        sample(16'h1234, "R1 R2");
        sample(16'h7FFF, "R2");
        sample(16'h8000, "R2");
        for (int i = 0; i < 40; i++) sample(int'($urandom_range(0, 65535)), "R1 R2 R3 R6");
        sample(16'hFF00, "R4");
        sample(16'hFF80, "R4");
        sample(16'hFFFF, "R4 R5");
        sample(16'hFC00, "R5");
        sample(16'hFE40, "R5");
        idle(6);

        // R8: writes out of range or with select 3 are ignored
        write(1, 69, 16'hDEAD);
        write(3, 5, 16'hBEEF);
        write(2, 133, 16'h7777);
        sample(5 * 1024 + 100, "R8");
        sample(5 * 1024 + 900, "R8");
        sample(4 * 1024 + 700, "R8");
        idle(6);

        // descending compander: negative spans, coordinate at top entry
        for (int k = 0; k < 256; k++) write(0, k, 65535 - k * 257);
        sample(0, "R3 R5");
        sample(16'hFFFF, "R4");
        for (int i = 0; i < 30; i++) sample(int'($urandom_range(0, 65535)), "R2 R3");
        idle(6);

        // quadratic compander
        for (int k = 0; k < 256; k++) write(0, k, k * k);
        for (int i = 0; i < 30; i++) sample(int'($urandom_range(0, 65535)), "R2 R3");

        // R9: compander rewrite in the middle of a stream
        for (int i = 0; i < 12; i++) begin
            if (i == 5)
                step(1'b1, 16'h4000 + i * 20, 1'b1, 0, 16'h40, 12345, "R9");
            else if (i == 8)
                step(1'b1, 16'h4000 + i * 20, 1'b1, 0, 16'h41, 300, "R9");
            else
                sample(16'h4000 + i * 20, "R9");
        end
        idle(6);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule